// File: doc/BRIEF.md
# Instruction Address Translation Unit

This unit turns an instruction-fetch virtual address into a physical address, one request per cycle. Each request uses the current privilege mode, a superpage control field, the current address-space number and a page-table base. The unit offers the page number and address-space number to an external translation lookaside buffer through a combinational lookup port. From the answer, and from the address itself, it returns one of three things: a physical address with an uncacheable flag, a miss fault, or an access-violation fault. Storage of the translations and refill on a miss belong to the surrounding logic.

On a fault that belongs to the correct path, the unit records two values: the faulting address, and a formatted address that points at the page-table entry for the page. A wrong-path request leaves both records as they were. Free-running counters keep totals of hits, misses and violations, and an access total equal to hits plus misses. Pages are 8 KiB. The implemented virtual space is 43 bits, sign-extended to 64. The implemented physical space is 44 bits, and its top bit marks uncached space.

Top module: `itrans_unit`

## Requirements
- R1: A request whose address has bit 0 set skips translation entirely, whatever its other bits, the mode or the lookup answer. It returns no fault (code 0) with a physical address equal to address bits 43:0 with bits 1:0 forced to zero, and it counts as a hit.
- R2: Bit 0 clear and address bits 63:42 not all equal gives an access violation (code 2).
- R3: Superpage window in kernel mode (mode 0). If bit 1 of the superpage control field is set and address bits 42:41 equal binary 10, the lookup answer is ignored. The response carries no fault and a physical address equal to address bits 43:0, and it counts as a hit.
- R4: The same superpage window in any mode other than kernel (1, 2 or 3) gives an access violation (code 2).
- R5: Outside the bypass and the superpage window, a valid address with the lookup reporting no match gives a miss fault (code 1).
- R6: On a match with permission, the physical address is the 31-bit frame number in bits 43:13, address bits 12:2 in bits 12:2, and zeros in bits 1:0.
- R7: On a match, execution is allowed only when bit [mode] of the entry's 4-bit read-enable mask is set. Otherwise the result is an access violation (code 2).
- R8: On a fault from a request not marked wrong-path, the tag record takes the full address. The formatted record takes the page-table base OR (address shifted right by 13, then left by 3). Wrong-path faults and fault-free responses leave both records unchanged.
- R9: The uncacheable flag is set exactly when the response has no fault and physical address bit 43 is set.
- R10: Each request adds one to exactly one of the hit, miss and violation counters, wrong-path requests included. The access counter always equals hits plus misses.
- R11: The lookup port shows address bits 42:13 as the page number and the current address-space number, in the same cycle as the request.
- R12: Responses are registered: the response to a request appears in the next cycle. A cycle without a request gives a response-valid of zero and no change to records or counters. Reset clears every response, record and counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_va | input | 64 | Fetch virtual address |
| req_wrongpath | input | 1 | Request is on a mispredicted path |
| cur_mode | input | 2 | Mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| spage_ctl | input | 2 | Superpage control; bit 1 enables the window |
| cur_asn | input | 8 | Current address-space number |
| pt_base | input | 64 | Page-table base for the formatted record |
| tlb_vpn | output | 30 | Lookup page number |
| tlb_asn | output | 8 | Lookup address-space number |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_pfn | input | 31 | Frame number of the matching entry |
| tlb_rd_en | input | 4 | Read-enable mask of the entry, one bit per mode |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 44 | Physical address (zero on a fault) |
| rsp_uncached | output | 1 | Physical address lies in uncached space |
| rsp_fault | output | 2 | 0 none, 1 miss, 2 access violation |
| flt_tag | output | 64 | Recorded faulting address |
| flt_form | output | 64 | Recorded page-table-entry address |
| cnt_hit | output | 32 | Hit total |
| cnt_miss | output | 32 | Miss total |
| cnt_acv | output | 32 | Violation total |
| cnt_access | output | 32 | Hits plus misses |

## Verification
The lookup port is combinational, so it is checked one time unit after the inputs change, in the same cycle as the request. Every other result comes from a single register stage. The response, both fault records and all four counters are due exactly one rising edge after the request. The bench drives each request on a falling edge and computes the expected state from its own model. It compares the whole response shortly after the next rising edge, idle cycles included, so each result is sampled in the cycle it is due and never near an edge.

// File: rtl/itrans_unit.sv
module itrans_unit #(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int PA_W    = 44,
  parameter int PG_BITS = 13,
  parameter int ASN_W   = 8,
  parameter int CNT_W   = 32,
  localparam int VPN_W  = VA_IMPL - PG_BITS,
  localparam int PFN_W  = PA_W - PG_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_wrongpath,
  input  logic [1:0]       cur_mode,
  input  logic [1:0]       spage_ctl,
  input  logic [ASN_W-1:0] cur_asn,
  input  logic [VA_W-1:0]  pt_base,
  output logic [VPN_W-1:0] tlb_vpn,
  output logic [ASN_W-1:0] tlb_asn,
  input  logic             tlb_hit,
  input  logic [PFN_W-1:0] tlb_pfn,
  input  logic [3:0]       tlb_rd_en,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_uncached,
  output logic [1:0]       rsp_fault,
  output logic [VA_W-1:0]  flt_tag,
  output logic [VA_W-1:0]  flt_form,
  output logic [CNT_W-1:0] cnt_hit,
  output logic [CNT_W-1:0] cnt_miss,
  output logic [CNT_W-1:0] cnt_acv,
  output logic [CNT_W-1:0] cnt_access
);
  localparam logic [1:0] F_NONE = 2'd0;
  localparam logic [1:0] F_MISS = 2'd1;
  localparam logic [1:0] F_ACV  = 2'd2;
  localparam int         EXT_W  = VA_W - VA_IMPL + 1;

  logic [EXT_W-1:0] ext_bits;
  logic             priv_pc, va_ok, in_spage, is_kernel;
  logic [1:0]       fault_n;
  logic [PA_W-1:0]  pa_n;
  logic [VA_W-1:0]  form_n;

  assign tlb_vpn   = req_va[VA_IMPL-1:PG_BITS];
  assign tlb_asn   = cur_asn;
  assign ext_bits  = req_va[VA_W-1:VA_IMPL-1];
  assign priv_pc   = req_va[0];
  assign va_ok     = (&ext_bits) | ~(|ext_bits);
  assign in_spage  = spage_ctl[1] && (req_va[VA_IMPL-1:VA_IMPL-2] == 2'b10);
  assign is_kernel = (cur_mode == 2'd0);
  assign form_n    = pt_base | ((req_va >> PG_BITS) << 3);

  always_comb begin
    fault_n = F_NONE;
    pa_n    = '0;
    if (priv_pc) begin
      pa_n = {req_va[PA_W-1:2], 2'b00};
    end else if (!va_ok) begin
      fault_n = F_ACV;
    end else if (in_spage) begin
      if (is_kernel) pa_n = req_va[PA_W-1:0];
      else           fault_n = F_ACV;
    end else if (!tlb_hit) begin
      fault_n = F_MISS;
    end else if (!tlb_rd_en[cur_mode]) begin
      fault_n = F_ACV;
    end else begin
      pa_n = {tlb_pfn, req_va[PG_BITS-1:2], 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_pa       <= '0;
      rsp_uncached <= 1'b0;
      rsp_fault    <= F_NONE;
      flt_tag      <= '0;
      flt_form     <= '0;
      cnt_hit      <= '0;
      cnt_miss     <= '0;
      cnt_acv      <= '0;
      cnt_access   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault    <= fault_n;
        rsp_pa       <= pa_n;
        rsp_uncached <= (fault_n == F_NONE) && pa_n[PA_W-1];
        if (fault_n != F_NONE && !req_wrongpath) begin
          flt_tag  <= req_va;
          flt_form <= form_n;
        end
        case (fault_n)
          F_NONE:  begin cnt_hit  <= cnt_hit + 1'b1;  cnt_access <= cnt_access + 1'b1; end
          F_MISS:  begin cnt_miss <= cnt_miss + 1'b1; cnt_access <= cnt_access + 1'b1; end
          default: cnt_acv <= cnt_acv + 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/itrans_unit_chk.sv
module itrans_unit_chk #(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int PA_W    = 44,
  parameter int CNT_W   = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_va,
  input logic             req_wrongpath,
  input logic [1:0]       spage_ctl,
  input logic [1:0]       cur_mode,
  input logic             tlb_hit,
  input logic             rsp_valid,
  input logic [PA_W-1:0]  rsp_pa,
  input logic             rsp_uncached,
  input logic [1:0]       rsp_fault,
  input logic [VA_W-1:0]  flt_tag,
  input logic [VA_W-1:0]  flt_form,
  input logic [CNT_W-1:0] cnt_hit,
  input logic [CNT_W-1:0] cnt_miss,
  input logic [CNT_W-1:0] cnt_access
);
  logic ok_va, sp_win;
  assign ok_va  = (&req_va[VA_W-1:VA_IMPL-1]) | ~(|req_va[VA_W-1:VA_IMPL-1]);
  assign sp_win = spage_ctl[1] && (req_va[VA_IMPL-1:VA_IMPL-2] == 2'b10);

  a_r1_bypass_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_va[0] |=> rsp_valid && rsp_fault == 2'd0);
  a_r2_bad_va_acv: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_va[0] && !ok_va |=> rsp_fault == 2'd2);
  a_r4_spage_user_acv: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_va[0] && ok_va && sp_win && cur_mode != 2'd0 |=> rsp_fault == 2'd2);
  a_r5_miss: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_va[0] && ok_va && !sp_win && !tlb_hit |=> rsp_fault == 2'd1);
  a_r8_wrongpath_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_wrongpath |=> $stable(flt_tag) && $stable(flt_form));
  a_r9_uncached_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncached |-> rsp_fault == 2'd0 && rsp_pa[PA_W-1]);
  a_r10_access_sum: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_access == cnt_hit + cnt_miss);
  a_r12_idle_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

bind itrans_unit itrans_unit_chk #(.VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/itrans_unit_test.sv
module itrans_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic        req_wrongpath = 1'b0;
  logic [1:0]  cur_mode = '0;
  logic [1:0]  spage_ctl = '0;
  logic [7:0]  cur_asn = 8'h5A;
  logic [63:0] pt_base = 64'h0000_0200_0000_0000;
  logic [29:0] tlb_vpn;
  logic [7:0]  tlb_asn;
  logic        tlb_hit = 1'b0;
  logic [30:0] tlb_pfn = '0;
  logic [3:0]  tlb_rd_en = '0;
  logic        rsp_valid, rsp_uncached;
  logic [43:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic [63:0] flt_tag, flt_form;
  logic [31:0] cnt_hit, cnt_miss, cnt_acv, cnt_access;

  int checks = 0, errors = 0;
  logic [63:0] e_tag = '0, e_form = '0;
  int e_hit = 0, e_miss = 0, e_acv = 0;

  always #5 clk = ~clk;

  itrans_unit uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input logic vld, input logic [1:0] f, input logic [43:0] pa, input logic unc);
    chk("R12 rsp_valid", 64'(rsp_valid), 64'(vld));
    if (vld) begin
      chk("R1-R7 fault code", 64'(rsp_fault), 64'(f));
      chk("R1/R3/R6 phys addr", 64'(rsp_pa), 64'(pa));
      chk("R9 uncached", 64'(rsp_uncached), 64'(unc));
    end
    chk("R8 tag record", flt_tag, e_tag);
    chk("R8 form record", flt_form, e_form);
    chk("R10 hit count", 64'(cnt_hit), 64'(e_hit));
    chk("R10 miss count", 64'(cnt_miss), 64'(e_miss));
    chk("R10 acv count", 64'(cnt_acv), 64'(e_acv));
    chk("R10 access count", 64'(cnt_access), 64'(e_hit + e_miss));
  endtask

  task automatic issue(input logic [63:0] va, input logic wp, input logic [1:0] md,
                       input logic [1:0] spc, input logic hit, input logic [30:0] pfn,
                       input logic [3:0] rden);
    logic [1:0]  code;
    logic [43:0] pa;
    logic        good;
    @(negedge clk);
    req_va = va; req_wrongpath = wp; cur_mode = md; spage_ctl = spc;
    tlb_hit = hit; tlb_pfn = pfn; tlb_rd_en = rden; req_valid = 1'b1;
    #1;
    chk("R11 lookup page", 64'(tlb_vpn), 64'(va[42:13]));
    chk("R11 lookup asn", 64'(tlb_asn), 64'(cur_asn));
    good = (va[63:42] == '1) || (va[63:42] == '0);
    code = 2'd0; pa = '0;
    if (va[0]) pa = va[43:0] & ~44'h3;
    else if (!good) code = 2'd2;
    else if (spc[1] && va[42:41] == 2'b10) begin
      if (md == 2'd0) pa = va[43:0]; else code = 2'd2;
    end
    else if (!hit) code = 2'd1;
    else if (!rden[md]) code = 2'd2;
    else pa = {pfn, va[12:2], 2'b00};
    if (code == 2'd0) e_hit++; else if (code == 2'd1) e_miss++; else e_acv++;
    if (code != 2'd0 && !wp) begin
      e_tag = va;
      e_form = pt_base | ((va >> 13) << 3);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk_state(1'b1, code, pa, (code == 2'd0) && pa[43]);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_state(1'b0, 2'd0, '0, 1'b0);   // R12 reset state
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk_state(1'b0, 2'd0, '0, 1'b0);   // R12 idle after reset
    // R1 bypass, TLB says miss, low bits cleared
    issue(64'h0000_0000_0012_3457, 0, 2'd3, 2'b00, 0, '0, 4'h0);
    // R1 bypass with an invalid address and bit 43 set (R9)
    issue(64'h1234_F800_0000_1001, 0, 2'd3, 2'b10, 0, '0, 4'h0);
    // R2 invalid address
    issue(64'h0000_8000_0000_2000, 0, 2'd0, 2'b00, 1, 31'h1, 4'hF);
    // R3 superpage in kernel, TLB ignored
    issue(64'hFFFF_FC00_0001_2344, 0, 2'd0, 2'b10, 0, '0, 4'h0);
    // R4 superpage in user mode
    issue(64'hFFFF_FC00_0001_2344, 0, 2'd3, 2'b10, 1, 31'h7, 4'hF);
    // superpage control bit 1 clear: goes through lookup (R6)
    issue(64'hFFFF_FC00_0001_2344, 0, 2'd0, 2'b01, 1, 31'h0ABC, 4'h1);
    // R5 miss, recorded
    issue(64'h0000_0000_1234_6008, 0, 2'd2, 2'b00, 0, '0, 4'h0);
    // R8 wrong-path miss leaves records
    issue(64'h0000_0000_5555_8000, 1, 2'd2, 2'b00, 0, '0, 4'h0);
    // R7 permission granted in user mode only
    issue(64'h0000_0000_0040_1ffc, 0, 2'd3, 2'b00, 1, 31'h12345, 4'b1000);
    issue(64'h0000_0000_0040_1ffc, 0, 2'd3, 2'b00, 1, 31'h12345, 4'b0111);
    issue(64'h0000_0000_0040_1ffc, 0, 2'd1, 2'b00, 1, 31'h12345, 4'b0010);
    // R9 uncached frame via lookup
    issue(64'h0000_0000_0000_2006, 0, 2'd0, 2'b00, 1, 31'h4000_0001, 4'h1);
    // R12 idle cycle
    @(negedge clk); @(posedge clk); #1;
    chk_state(1'b0, 2'd0, '0, 1'b0);
    // mixed patterns
    for (int i = 0; i < 60; i++) begin
      logic [63:0] v;
      v = {$urandom, $urandom};
      if (i % 3 != 0) v[63:43] = {21{v[42]}};
      if (i % 5 == 0) v[42:41] = 2'b10;
      cur_asn = 8'($urandom);
      issue(v, 1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
            31'($urandom), 4'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule